// File: doc/BRIEF.md
# SPI Master Chip-Select Controller

This block owns the four active-low chip-select lines of an SPI master. It takes transmit words over a valid/ready handshake. For each word it works out which peripheral is addressed, drives the select lines, and hands the payload, the transfer length and the chosen configuration-set index to a separate shift engine with a one-cycle start strobe. The shift engine returns a one-cycle done strobe when the word has been shifted out.

The target comes from one of two places. In fixed mode it is a 4-bit code supplied as a mode setting. In variable mode it is a code carried inside every transmit word, so consecutive words may go to different peripherals. The code reaches the lines in one of two styles. In the priority style, exactly one line is pulled low. In the decoded style, the raw code is driven for an external decoder that serves up to fifteen peripherals. Four length settings are shared among the possible targets.

Back-to-back words to the same target keep the lines asserted. A word flagged as final, a change of target, or an empty input returns all lines high.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After reset, and whenever no word is being shifted, `cs_n` is 4'hF. After reset `xfer_start` is 0 and `tx_ready` is 1.
- R2: With `mode_var`=0 the select code is `fixed_code`, and bits [19:16] of `tx_word` have no effect on `cs_n` or `set_sel`.
- R3: With `mode_var`=1 the select code of each word is `tx_word[19:16]`, taken afresh for every word.
- R4: `xfer_data` carries `tx_word[15:0]` of the word being shifted. `tx_word[24]` is the final-word flag. Bits [23:20] and [31:25] are ignored.
- R5: With `mode_decode`=0 exactly the lowest-numbered line whose code bit is 0 is driven low, so at most one bit of `cs_n` is 0.
- R6: With `mode_decode`=1, `cs_n` equals the select code for the whole word.
- R7: `set_sel` is code[3:2] when decoding. Without decoding it is the index of the asserted line, or 0 when no line is asserted.
- R8: `xfer_len` equals `set_len[5*k+4:5*k]`, where k is `set_sel`. Each field holds a length from 8 to 16.
- R9: If `xfer_done` arrives for a non-final word while a word with the same code is waiting, that word is accepted in the same cycle and `cs_n` stays unchanged. A waiting word with a different code is accepted only after `cs_n` has been 4'hF for at least one cycle.
- R10: After `xfer_done` for a word whose final flag is set, `cs_n` returns to 4'hF even if another word is waiting.
- R11: Code 4'hF without decoding asserts no line, but the word is still started and shifted with `set_sel`=0.
- R12: `xfer_done` while no word is in flight has no effect.
- R13: A word accepted on a clock edge raises `xfer_start` for exactly one cycle and updates `cs_n`, `xfer_data`, `xfer_len` and `set_sel` on that same edge. Lines return high on the edge that samples the final `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_var | input | 1 | 1: code from each word; 0: code from `fixed_code` |
| mode_decode | input | 1 | 1: raw code on lines; 0: single-line priority |
| fixed_code | input | 4 | Select code used in fixed mode |
| set_len | input | 20 | Four 5-bit transfer lengths, set k at [5k+4:5k] |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted when high with `tx_valid` |
| tx_word | input | 32 | Transmit word (data, code, final flag) |
| xfer_done | input | 1 | Shift engine finished the current word |
| xfer_start | output | 1 | One-cycle start strobe to the shift engine |
| xfer_data | output | 16 | Payload of the current word |
| xfer_len | output | 5 | Bit count for the current word |
| set_sel | output | 2 | Configuration-set index of the current word |
| cs_n | output | 4 | Active-low chip-select lines |

## Verification
`tx_ready` is combinational and is due in the same cycle as `tx_valid` and `xfer_done`. The start strobe, the new line value, the payload, the length and the set index all appear on the edge that accepts a word. The return of the lines to all-high appears on the edge that samples the final done. Inputs change on the falling edge. A behavioural model updates on each rising edge, and every output is compared with it 2 ns after each falling edge, so each result is read in the cycle it becomes due. Further checks wait for each start strobe and compare the lines, length and payload against literal values taken from the requirements, and they count high cycles between strobes to check chaining and the final flag.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    localparam int CS_LINES  = 4;
    localparam int CODE_W    = CS_LINES;
    localparam int NUM_SETS  = 4;
    localparam int SET_W     = $clog2(NUM_SETS);
    localparam int LEN_W     = 5;
    localparam int DATA_W    = 16;
    localparam int WORD_W    = 32;
    localparam int CODE_LSB  = 16;
    localparam int LAST_POS  = 24;

    typedef logic [CODE_W-1:0] cs_code_t;
    typedef logic [SET_W-1:0]  set_idx_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        cs_code_t          code;
        logic              last;
    } tx_fields_t;

    typedef struct packed {
        cs_code_t lines_n;
        set_idx_t set_idx;
    } cs_route_t;

    function automatic tx_fields_t split_word(input logic [WORD_W-1:0] w);
        tx_fields_t f;
        f.data = w[DATA_W-1:0];
        f.code = w[CODE_LSB +: CODE_W];
        f.last = w[LAST_POS];
        return f;
    endfunction

    function automatic set_idx_t lowest_zero(input cs_code_t c);
        set_idx_t r;
        casez (c)
            4'b???0: r = 2'd0;
            4'b??01: r = 2'd1;
            4'b?011: r = 2'd2;
            4'b0111: r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cs_word_pick.sv
module cs_word_pick
    import spi_cs_pkg::*;
(
    input  logic              var_sel,
    input  cs_code_t          fixed_code,
    input  logic [WORD_W-1:0] word,
    output tx_fields_t        fields
);
    tx_fields_t raw;

    always_comb begin
        raw    = split_word(word);
        fields = raw;
        if (!var_sel) fields.code = fixed_code;
    end
endmodule

// File: rtl/cs_route.sv
module cs_route
    import spi_cs_pkg::*;
(
    input  logic      decode,
    input  cs_code_t  code,
    output cs_route_t route
);
    logic [CS_LINES:0]   lower_high;
    logic [CS_LINES-1:0] single_n;

    assign lower_high[0] = 1'b1;

    for (genvar g = 0; g < CS_LINES; g++) begin : g_line
        assign lower_high[g+1] = lower_high[g] & code[g];
        assign single_n[g]     = ~(~code[g] & lower_high[g]);
    end

    always_comb begin
        if (decode) begin
            route.lines_n = code;
            route.set_idx = code[CODE_W-1 -: SET_W];
        end else begin
            route.lines_n = single_n;
            route.set_idx = lowest_zero(code);
        end
    end
endmodule

// File: rtl/cs_len_sel.sv
module cs_len_sel
    import spi_cs_pkg::*;
(
    input  logic [NUM_SETS*LEN_W-1:0] lens,
    input  set_idx_t                  idx,
    output logic [LEN_W-1:0]          len
);
    logic [LEN_W-1:0] len_arr [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        assign len_arr[s] = lens[s*LEN_W +: LEN_W];
    end

    assign len = len_arr[idx];
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
    import spi_cs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_var,
    input  logic                      mode_decode,
    input  logic [CODE_W-1:0]         fixed_code,
    input  logic [NUM_SETS*LEN_W-1:0] set_len,
    input  logic                      tx_valid,
    output logic                      tx_ready,
    input  logic [WORD_W-1:0]         tx_word,
    input  logic                      xfer_done,
    output logic                      xfer_start,
    output logic [DATA_W-1:0]         xfer_data,
    output logic [LEN_W-1:0]          xfer_len,
    output logic [SET_W-1:0]          set_sel,
    output logic [CS_LINES-1:0]       cs_n
);
    tx_fields_t       nxt;
    cs_route_t        nxt_route;
    logic [LEN_W-1:0] nxt_len;

    logic     busy_q;
    logic     last_q;
    logic     dec_q;
    cs_code_t code_q;
    logic     accept;
    logic     chain_ok;

    cs_word_pick u_pick (
        .var_sel    (mode_var),
        .fixed_code (fixed_code),
        .word       (tx_word),
        .fields     (nxt)
    );

    cs_route u_route (
        .decode (mode_decode),
        .code   (nxt.code),
        .route  (nxt_route)
    );

    cs_len_sel u_len (
        .lens (set_len),
        .idx  (nxt_route.set_idx),
        .len  (nxt_len)
    );

    assign chain_ok = busy_q && xfer_done && !last_q && (nxt.code == code_q);
    assign tx_ready = !busy_q || chain_ok;
    assign accept   = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            last_q     <= 1'b0;
            dec_q      <= 1'b0;
            code_q     <= '1;
            cs_n       <= '1;
            xfer_start <= 1'b0;
            xfer_data  <= '0;
            xfer_len   <= '0;
            set_sel    <= '0;
        end else begin
            xfer_start <= 1'b0;
            if (accept) begin
                busy_q     <= 1'b1;
                last_q     <= nxt.last;
                dec_q      <= mode_decode;
                code_q     <= nxt.code;
                cs_n       <= nxt_route.lines_n;
                xfer_start <= 1'b1;
                xfer_data  <= nxt.data;
                xfer_len   <= nxt_len;
                set_sel    <= nxt_route.set_idx;
            end else if (busy_q && xfer_done) begin
                busy_q <= 1'b0;
                cs_n   <= '1;
            end
        end
    end

    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> cs_n == '1);

    a_r5_single_line: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !dec_q) |-> $countones(~cs_n) <= 1);

    a_r13_start_on_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> (xfer_start && busy_q));

    a_r9_chain_holds_lines: assert property (@(posedge clk) disable iff (rst)
        (busy_q && xfer_done && accept) |=> $stable(cs_n));

    a_r10_final_releases: assert property (@(posedge clk) disable iff (rst)
        (busy_q && xfer_done && last_q) |=> (cs_n == '1 && !xfer_start));

    a_r12_stray_done: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && xfer_done && !tx_valid) |=> (cs_n == '1 && !xfer_start));
endmodule

// File: tb/tb_spi_cs_ctrl.sv
module tb_spi_cs_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_var = 1'b0;
    logic        mode_decode = 1'b0;
    logic [3:0]  fixed_code = 4'hF;
    logic [19:0] set_len = {5'd10, 5'd16, 5'd12, 5'd8};
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] tx_word = '0;
    logic        xfer_done = 1'b0;
    logic        xfer_start;
    logic [15:0] xfer_data;
    logic [4:0]  xfer_len;
    logic [1:0]  set_sel;
    logic [3:0]  cs_n;

    always #5 clk = ~clk;

    spi_cs_ctrl dut (
        .clk(clk), .rst(rst), .mode_var(mode_var), .mode_decode(mode_decode),
        .fixed_code(fixed_code), .set_len(set_len), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_word(tx_word), .xfer_done(xfer_done),
        .xfer_start(xfer_start), .xfer_data(xfer_data), .xfer_len(xfer_len),
        .set_sel(set_sel), .cs_n(cs_n)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    logic [31:0] wq[$];
    logic  inject = 1'b0;
    int    cycles = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [15:0] d, input logic [3:0] c, input bit fin);
        return {7'h2A, fin, 4'h9, c, d};
    endfunction

    function automatic logic [3:0] eff_code(input logic [31:0] w);
        return mode_var ? w[19:16] : fixed_code;
    endfunction

    function automatic int first_zero(input logic [3:0] c);
        for (int i = 0; i < 4; i++) if (!c[i]) return i;
        return -1;
    endfunction

    function automatic logic [3:0] exp_lines(input logic [3:0] c);
        logic [3:0] r;
        int p;
        if (mode_decode) return c;
        r = 4'hF;
        p = first_zero(c);
        if (p >= 0) r[p] = 1'b0;
        return r;
    endfunction

    function automatic logic [1:0] exp_set(input logic [3:0] c);
        int p;
        if (mode_decode) return c[3:2];
        p = first_zero(c);
        return (p < 0) ? 2'd0 : 2'(p);
    endfunction

    // behavioural reference model
    bit         m_act = 0, m_last = 0, m_start = 0, m_acc = 0;
    logic [3:0] m_code = 4'hF, m_lines = 4'hF;
    logic [15:0] m_data = '0;
    logic [4:0] m_len = '0;
    logic [1:0] m_set = '0;

    function automatic bit m_ready();
        return !m_act || (xfer_done && !m_last && tx_valid && eff_code(tx_word) == m_code);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act <= 0; m_start <= 0; m_acc <= 0; m_lines <= 4'hF;
            m_data <= '0; m_len <= '0; m_set <= '0; m_last <= 0;
        end else if (tx_valid && m_ready()) begin
            m_acc   <= 1; m_act <= 1; m_start <= 1;
            m_code  <= eff_code(tx_word);
            m_last  <= tx_word[24];
            m_lines <= exp_lines(eff_code(tx_word));
            m_data  <= tx_word[15:0];
            m_set   <= exp_set(eff_code(tx_word));
            m_len   <= set_len[5*exp_set(eff_code(tx_word)) +: 5];
        end else begin
            m_acc <= 0; m_start <= 0;
            if (m_act && xfer_done) begin
                m_act <= 0; m_lines <= 4'hF;
            end
        end
    end

    // per-cycle comparison, 2 ns after the falling edge
    initial forever begin
        @(negedge clk); #2;
        if (!rst) begin
            chk(cs_n == m_lines, cur_req, "cs_n", 32'(cs_n), 32'(m_lines));
            chk(tx_ready == m_ready(), cur_req, "tx_ready", 32'(tx_ready), 32'(m_ready()));
            chk(xfer_start == m_start, cur_req, "xfer_start", 32'(xfer_start), 32'(m_start));
            if (m_act) begin
                chk(xfer_data == m_data, cur_req, "xfer_data", 32'(xfer_data), 32'(m_data));
                chk(xfer_len == m_len, cur_req, "xfer_len", 32'(xfer_len), 32'(m_len));
                chk(set_sel == m_set, cur_req, "set_sel", 32'(set_sel), 32'(m_set));
            end
        end
    end

    // word driver
    initial forever begin
        @(negedge clk);
        if (tx_valid && m_acc) tx_valid = 1'b0;
        if (!tx_valid && wq.size() > 0) begin
            tx_word  = wq.pop_front();
            tx_valid = 1'b1;
        end
    end

    // shift engine stand-in
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            xfer_done = inject;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) xfer_done = 1'b1;
            end
            if (xfer_start) cnt = 1 + int'(xfer_data[1:0]);
        end
    end

    task automatic wait_start(output int gap);
        gap = 0;
        do begin
            @(negedge clk); #2;
            if (cs_n == 4'hF && !xfer_start) gap++;
        end while (!xfer_start);
    endtask

    task automatic expect_word(input string tag, input logic [3:0] ecs,
                               input logic [4:0] elen, input logic [15:0] edat,
                               output int gap);
        wait_start(gap);
        chk(cs_n == ecs, tag, "cs_n at start", 32'(cs_n), 32'(ecs));
        chk(xfer_len == elen, tag, "xfer_len at start", 32'(xfer_len), 32'(elen));
        chk(xfer_data == edat, tag, "xfer_data at start", 32'(xfer_data), 32'(edat));
    endtask

    task automatic drain();
        while (wq.size() > 0 || tx_valid || m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                fails++;
                checks++;
                $display("FAIL watchdog R13 actual=%0d expected=%0d", cycles, 50000);
                summary();
            end
        end
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk(cs_n == 4'hF, "R1", "cs_n after reset", 32'(cs_n), 32'hF);
        chk(!xfer_start, "R1", "xfer_start after reset", 32'(xfer_start), 0);
        chk(tx_ready, "R1", "tx_ready after reset", 32'(tx_ready), 1);

        // R2 fixed mode: word code field ignored
        cur_req = "R2 R8";
        mode_var = 0; mode_decode = 0; fixed_code = 4'b1011;
        wq.push_back(mk(16'hA1B0, 4'b0111, 1));
        expect_word("R2", 4'b1011, 5'd16, 16'hA1B0, g);
        chk(set_sel == 2'd2, "R7", "set_sel fixed", 32'(set_sel), 2);
        drain();

        // R3 R5 variable mode, priority resolution, R13 timing via model
        cur_req = "R3 R5 R13";
        mode_var = 1;
        wq.push_back(mk(16'h0011, 4'b1010, 0));
        wq.push_back(mk(16'h0022, 4'b0110, 0));
        wq.push_back(mk(16'h0033, 4'b0111, 0));
        wq.push_back(mk(16'h0041, 4'b1101, 1));
        expect_word("R5", 4'b1110, 5'd8, 16'h0011, g);
        expect_word("R3", 4'b1110, 5'd8, 16'h0022, g);
        chk(g > 0, "R9", "gap on code change", 32'(g), 1);
        expect_word("R5", 4'b0111, 5'd10, 16'h0033, g);
        expect_word("R4", 4'b1101, 5'd12, 16'h0041, g);
        drain();

        // R6 R7 decoded output
        cur_req = "R6 R7";
        mode_decode = 1;
        wq.push_back(mk(16'h0100, 4'h0, 1));
        wq.push_back(mk(16'h0201, 4'h5, 1));
        wq.push_back(mk(16'h0302, 4'h9, 1));
        wq.push_back(mk(16'h0403, 4'hE, 1));
        expect_word("R6", 4'h0, 5'd8, 16'h0100, g);
        expect_word("R6", 4'h5, 5'd12, 16'h0201, g);
        expect_word("R7", 4'h9, 5'd16, 16'h0302, g);
        expect_word("R7", 4'hE, 5'd10, 16'h0403, g);
        chk(set_sel == 2'd3, "R7", "set_sel code 14", 32'(set_sel), 3);
        drain();

        // R9 chaining same code keeps lines low
        cur_req = "R9";
        mode_decode = 0;
        wq.push_back(mk(16'h1000, 4'b1101, 0));
        wq.push_back(mk(16'h1003, 4'b1101, 0));
        wq.push_back(mk(16'h1001, 4'b1101, 1));
        expect_word("R9", 4'b1101, 5'd12, 16'h1000, g);
        expect_word("R9", 4'b1101, 5'd12, 16'h1003, g);
        chk(g == 0, "R9", "no high gap in chain", 32'(g), 0);
        expect_word("R9", 4'b1101, 5'd12, 16'h1001, g);
        chk(g == 0, "R9", "no high gap in chain", 32'(g), 0);
        drain();

        // R10 final flag releases lines even with a word waiting
        cur_req = "R10";
        wq.push_back(mk(16'h2000, 4'b1011, 1));
        wq.push_back(mk(16'h2001, 4'b1011, 1));
        expect_word("R10", 4'b1011, 5'd16, 16'h2000, g);
        expect_word("R10", 4'b1011, 5'd16, 16'h2001, g);
        chk(g > 0, "R10", "high gap after final word", 32'(g), 1);
        drain();

        // R11 code F without decoding
        cur_req = "R11";
        wq.push_back(mk(16'h3002, 4'hF, 1));
        expect_word("R11", 4'hF, 5'd8, 16'h3002, g);
        chk(set_sel == 2'd0, "R11", "set_sel for code F", 32'(set_sel), 0);
        drain();

        // R12 stray done while idle
        cur_req = "R12";
        @(negedge clk); inject = 1'b1;
        @(negedge clk); inject = 1'b0; #2;
        chk(cs_n == 4'hF, "R12", "cs_n after stray done", 32'(cs_n), 32'hF);
        chk(!xfer_start, "R12", "no start after stray done", 32'(xfer_start), 0);
        chk(tx_ready, "R12", "ready after stray done", 32'(tx_ready), 1);
        repeat (3) @(negedge clk);

        summary();
    end
endmodule